// File: doc/BRIEF.md
# HDLC Bit-Synchronous Frame Transmitter

This block turns frames supplied by a host one byte at a time into a bit-synchronous HDLC/SDLC serial stream. The host presents bytes on a valid/ready interface. Each byte carries a start-of-frame marker, an end-of-frame marker and, for the final byte, a count of how many of its low bits belong to the frame. That count lets a frame end on any bit, not only on a byte boundary. The transmitter sends one line bit for every cycle in which the bit-clock strobe is high, so a single system clock serves any line rate.

Around the frame content the block adds an opening and a closing flag. It inserts a zero after every run of five ones in the content, and it appends a 16-bit frame check sequence computed with the CCITT polynomial. Between frames the line carries either back-to-back flags or a steady mark level, chosen by a configuration input.

If the host has not supplied the next byte when the serializer finishes the current one, the frame is cut off with an abort run of ones. A one-cycle underrun pulse is raised, and the line returns to inter-frame fill.

Top module: `sdlc_tx_top`

## Requirements
- R1: During and directly after reset, `line_out` is 1, `in_ready` is 1 and `underrun` is 0.
- R2: Between frames, with `fill_flags` at 0 the line carries continuous 1s. With `fill_flags` at 1 it carries repeated flags 0x7E.
- R3: Every frame is sent as an opening flag 0x7E, the content, the check sequence and a closing flag 0x7E. Content bytes go out least-significant bit first.
- R4: In the content and the check sequence, a 0 is inserted after each run of five consecutive 1s. Flags and abort bits are never stuffed, and the run count restarts at each flag.
- R5: The check sequence is the CRC with reflected polynomial 0x8408, preset to 0xFFFF and advanced over every content bit sent. Its ones-complement goes out bit 0 first, so the digits "123456789" give 0x906E.
- R6: On a byte marked end-of-frame, `in_tail_bits` values 1 to 7 send only that many low bits of the byte. The value 0 sends all 8 bits. On other bytes the field is ignored.
- R7: If no byte is held when the last bit of a non-final byte is sent, the next eight line bits are 1s. `underrun` is high for exactly one clock, in the cycle after that strobe, and inter-frame fill follows.
- R8: A single holding register sits between the host and the serializer. `in_ready` is high exactly when it is empty, a byte is taken on a clock edge with `in_valid` and `in_ready` both high, and `in_ready` is low in the next cycle.
- R9: A byte presented between frames without the start-of-frame marker is discarded at the end of the current fill unit. No frame is produced and `in_ready` returns to 1.
- R10: `line_out` changes only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock strobe; one line bit per high cycle |
| fill_flags | input | 1 | Inter-frame fill: 1 flags, 0 mark (ones) |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Holding register empty |
| in_data | input | 8 | Frame byte, bit 0 sent first |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_tail_bits | input | 3 | Valid low bits of the last byte, 0 meaning 8 |
| line_out | output | 1 | Serial line bit |
| underrun | output | 1 | One-clock pulse when a frame is aborted for lack of data |

## Verification
The line is decoded by an independent receiver model that hunts for flags, removes stuffed zeros and splits the check sequence off, and every decoded frame is compared against one built from the byte list and the CRC definition.

The patterns are chosen to tell particular faults apart:
- The known digit string separates a wrong preset, polynomial or bit order.
- Dense runs of ones, including 0x7E and 0xFF inside the content, show stuffing that is missing, misplaced or carried wrongly across into the check sequence.
- Frames ending in one and three residual bits expose an off-by-one in the tail count.
- A frame whose host stops after its first byte, a stray byte without a start marker, and frames sent under both fill modes separate the abort, discard and fill paths from ordinary framing.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    localparam int unsigned OCTET_W   = 8;
    localparam int unsigned FCS_W     = 16;
    localparam int unsigned NBITS_W   = $clog2(OCTET_W);
    localparam int unsigned SPAN_W    = $clog2(FCS_W + 1);
    localparam int unsigned STUFF_RUN = 5;

    localparam logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E;
    localparam logic [OCTET_W-1:0] MARK_OCTET = 8'hFF;
    localparam logic [FCS_W-1:0]   FCS_PRESET = 16'hFFFF;
    localparam logic [FCS_W-1:0]   FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_FILL  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_BODY  = 3'd2,
        ST_FCS   = 3'd3,
        ST_CLOSE = 3'd4,
        ST_ABORT = 3'd5
    } tx_state_e;

    typedef struct packed {
        logic [OCTET_W-1:0] data;
        logic               sof;
        logic               eof;
        logic [NBITS_W-1:0] nbits;
    } tx_octet_t;

    // One serial step of the reflected CCITT check.
    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] cur,
                                                  input logic             b);
        logic [FCS_W-1:0] shifted;
        shifted = cur >> 1;
        return (cur[0] ^ b) ? (shifted ^ FCS_POLY_R) : shifted;
    endfunction

    // Number of bits of this byte that belong to the frame.
    function automatic logic [SPAN_W-1:0] span_of(input tx_octet_t o);
        if (o.eof && (o.nbits != '0)) begin
            return SPAN_W'(o.nbits);
        end
        return SPAN_W'(OCTET_W);
    endfunction

endpackage

// File: rtl/sdlc_tx_hold.sv
module sdlc_tx_hold
    import sdlc_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push_valid,
    input  tx_octet_t push_octet,
    output logic      push_ready,
    input  logic      pop,
    output logic      full,
    output tx_octet_t held
);

    assign push_ready = !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else begin
            if (pop) begin
                full <= 1'b0;
            end
            if (push_valid && push_ready) begin
                full <= 1'b1;
                held <= push_octet;
            end
        end
    end

endmodule

// File: rtl/sdlc_tx_fcs.sv
module sdlc_tx_fcs
    import sdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic             adv,
    input  logic             din,
    output logic [FCS_W-1:0] fcs_nxt
);

    logic [FCS_W-1:0] fcs_q;

    assign fcs_nxt = fcs_step(fcs_q, din);

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            fcs_q <= FCS_PRESET;
        end else if (adv) begin
            fcs_q <= fcs_nxt;
        end
    end

endmodule

// File: rtl/sdlc_tx_stuff.sv
module sdlc_tx_stuff
    import sdlc_tx_pkg::*;
#(
    parameter int unsigned RUN = STUFF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic counted,
    input  logic val,
    output logic insert
);

    localparam int unsigned CW = $clog2(RUN + 1);

    logic [CW-1:0] run_q;

    assign insert = (run_q == CW'(RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (adv) begin
            run_q <= (counted && val) ? run_q + CW'(1) : '0;
        end
    end

endmodule

// File: rtl/sdlc_tx_seq.sv
module sdlc_tx_seq
    import sdlc_tx_pkg::*;
#(
    parameter int unsigned ABORT_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             fill_flags,
    input  logic             held_full,
    input  tx_octet_t        held,
    input  logic             stuff_now,
    input  logic [FCS_W-1:0] fcs_nxt,
    output logic             take,
    output logic             fcs_preset,
    output logic             fcs_adv,
    output logic             fcs_din,
    output logic             run_adv,
    output logic             run_counted,
    output logic             run_val,
    output logic             line_out,
    output logic             underrun,
    output tx_state_e        state_o
);

    localparam int unsigned UNIT_MAX = (ABORT_BITS > OCTET_W) ? ABORT_BITS : OCTET_W;
    localparam int unsigned CNT_W    = $clog2(UNIT_MAX);
    localparam logic [CNT_W-1:0] OCT_END   = CNT_W'(OCTET_W - 1);
    localparam logic [CNT_W-1:0] ABORT_END = CNT_W'(ABORT_BITS - 1);

    tx_state_e          st_q, st_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [FCS_W-1:0]   sh_q, sh_n;
    logic [SPAN_W-1:0]  left_q, left_n;
    logic               last_q, last_n;
    logic               fill_q, fill_n;
    logic               line_q, line_n;
    logic               und_q, und_n;
    logic               mode;
    logic [OCTET_W-1:0] pat;
    logic [NBITS_W-1:0] idx;

    assign idx      = cnt_q[NBITS_W-1:0];
    assign line_out = line_q;
    assign underrun = und_q;
    assign state_o  = st_q;

    always_comb begin
        st_n        = st_q;
        cnt_n       = cnt_q;
        sh_n        = sh_q;
        left_n      = left_q;
        last_n      = last_q;
        fill_n      = fill_q;
        line_n      = line_q;
        und_n       = 1'b0;
        take        = 1'b0;
        fcs_preset  = 1'b0;
        fcs_adv     = 1'b0;
        fcs_din     = 1'b0;
        run_adv     = 1'b0;
        run_counted = 1'b0;
        run_val     = 1'b0;
        mode        = (cnt_q == '0) ? fill_flags : fill_q;
        pat         = mode ? FLAG_OCTET : MARK_OCTET;

        if (bit_en) begin
            run_adv = 1'b1;
            unique case (st_q)
                ST_FILL: begin
                    if (cnt_q == '0) begin
                        fill_n = fill_flags;
                    end
                    line_n = pat[idx];
                    if (cnt_q == OCT_END) begin
                        cnt_n = '0;
                        if (held_full) begin
                            if (held.sof) begin
                                st_n = ST_OPEN;
                            end else begin
                                take = 1'b1;
                            end
                        end
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end

                ST_OPEN: begin
                    line_n = FLAG_OCTET[idx];
                    if (cnt_q == OCT_END) begin
                        cnt_n      = '0;
                        take       = 1'b1;
                        sh_n       = {{(FCS_W-OCTET_W){1'b0}}, held.data};
                        left_n     = span_of(held);
                        last_n     = held.eof;
                        fcs_preset = 1'b1;
                        st_n       = ST_BODY;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end

                ST_BODY: begin
                    run_counted = 1'b1;
                    if (stuff_now) begin
                        line_n = 1'b0;
                    end else begin
                        line_n  = sh_q[0];
                        run_val = sh_q[0];
                        fcs_adv = 1'b1;
                        fcs_din = sh_q[0];
                        sh_n    = sh_q >> 1;
                        left_n  = left_q - SPAN_W'(1);
                        if (left_q == SPAN_W'(1)) begin
                            if (last_q) begin
                                sh_n   = ~fcs_nxt;
                                left_n = SPAN_W'(FCS_W);
                                st_n   = ST_FCS;
                            end else if (held_full) begin
                                take   = 1'b1;
                                sh_n   = {{(FCS_W-OCTET_W){1'b0}}, held.data};
                                left_n = span_of(held);
                                last_n = held.eof;
                            end else begin
                                st_n  = ST_ABORT;
                                cnt_n = '0;
                                und_n = 1'b1;
                            end
                        end
                    end
                end

                ST_FCS: begin
                    run_counted = 1'b1;
                    if (stuff_now) begin
                        line_n = 1'b0;
                    end else begin
                        line_n  = sh_q[0];
                        run_val = sh_q[0];
                        sh_n    = sh_q >> 1;
                        left_n  = left_q - SPAN_W'(1);
                        if (left_q == SPAN_W'(1)) begin
                            st_n  = ST_CLOSE;
                            cnt_n = '0;
                        end
                    end
                end

                ST_CLOSE: begin
                    if (stuff_now) begin
                        line_n      = 1'b0;
                        run_counted = 1'b1;
                    end else begin
                        line_n = FLAG_OCTET[idx];
                        if (cnt_q == OCT_END) begin
                            cnt_n = '0;
                            st_n  = ST_FILL;
                        end else begin
                            cnt_n = cnt_q + CNT_W'(1);
                        end
                    end
                end

                ST_ABORT: begin
                    line_n = 1'b1;
                    if (cnt_q == ABORT_END) begin
                        cnt_n = '0;
                        st_n  = ST_FILL;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end

                default: begin
                    st_n  = ST_FILL;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_FILL;
            cnt_q  <= '0;
            sh_q   <= '0;
            left_q <= '0;
            last_q <= 1'b0;
            fill_q <= 1'b0;
            line_q <= 1'b1;
            und_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            sh_q   <= sh_n;
            left_q <= left_n;
            last_q <= last_n;
            fill_q <= fill_n;
            line_q <= line_n;
            und_q  <= und_n;
        end
    end

endmodule

// File: rtl/sdlc_tx_top.sv
module sdlc_tx_top
    import sdlc_tx_pkg::*;
#(
    parameter int unsigned ABORT_BITS = 8,
    parameter int unsigned RUN_LIMIT  = STUFF_RUN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               fill_flags,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [OCTET_W-1:0] in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [NBITS_W-1:0] in_tail_bits,
    output logic               line_out,
    output logic               underrun
);

    tx_octet_t        in_octet;
    tx_octet_t        held;
    logic             held_full;
    logic             take;
    logic             fcs_preset;
    logic             fcs_adv;
    logic             fcs_din;
    logic [FCS_W-1:0] fcs_nxt;
    logic             run_adv;
    logic             run_counted;
    logic             run_val;
    logic             stuff_now;
    tx_state_e        seq_state;

    assign in_octet = '{data: in_data, sof: in_sof, eof: in_eof, nbits: in_tail_bits};

    sdlc_tx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .push_valid (in_valid),
        .push_octet (in_octet),
        .push_ready (in_ready),
        .pop        (take),
        .full       (held_full),
        .held       (held)
    );

    sdlc_tx_fcs u_fcs (
        .clk     (clk),
        .rst     (rst),
        .preset  (fcs_preset),
        .adv     (fcs_adv),
        .din     (fcs_din),
        .fcs_nxt (fcs_nxt)
    );

    sdlc_tx_stuff #(.RUN(RUN_LIMIT)) u_stuff (
        .clk     (clk),
        .rst     (rst),
        .adv     (run_adv),
        .counted (run_counted),
        .val     (run_val),
        .insert  (stuff_now)
    );

    sdlc_tx_seq #(.ABORT_BITS(ABORT_BITS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .fill_flags  (fill_flags),
        .held_full   (held_full),
        .held        (held),
        .stuff_now   (stuff_now),
        .fcs_nxt     (fcs_nxt),
        .take        (take),
        .fcs_preset  (fcs_preset),
        .fcs_adv     (fcs_adv),
        .fcs_din     (fcs_din),
        .run_adv     (run_adv),
        .run_counted (run_counted),
        .run_val     (run_val),
        .line_out    (line_out),
        .underrun    (underrun),
        .state_o     (seq_state)
    );

endmodule

// File: rtl/sdlc_tx_checker.sv
module sdlc_tx_checker
    import sdlc_tx_pkg::*;
#(
    parameter int unsigned RUN = STUFF_RUN
) (
    input logic      clk,
    input logic      rst,
    input logic      bit_en,
    input logic      in_valid,
    input logic      in_ready,
    input logic      line_out,
    input logic      underrun,
    input tx_state_e st
);

    logic       bit_en_d;
    logic       body_bit;
    logic [3:0] ones_run;

    // Track which emitted bits came from content or check states, and the run of ones before them.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_en_d <= 1'b0;
            body_bit <= 1'b0;
            ones_run <= '0;
        end else begin
            bit_en_d <= bit_en;
            if (bit_en) begin
                body_bit <= (st == ST_BODY) || (st == ST_FCS);
            end
            if (bit_en_d) begin
                ones_run <= line_out ? ((ones_run == 4'hF) ? ones_run : ones_run + 4'd1) : 4'd0;
            end
        end
    end

    assert_stuff_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_en_d && body_bit && line_out) |-> (ones_run < 4'(RUN)));

    assert_line_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_out));

    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    assert_abort_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |-> ($past(bit_en) && (st == ST_ABORT)));

    assert_hold_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

endmodule

bind sdlc_tx_top sdlc_tx_checker #(.RUN(RUN_LIMIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_out (line_out),
    .underrun (underrun),
    .st       (seq_state)
);

// File: tb/sim_sdlc_tx_top.sv
`timescale 1ns/1ps
module sim_sdlc_tx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       fill_flags = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [2:0] in_tail_bits = 3'd0;
    logic       line_out;
    logic       underrun;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdlc_tx_top u0 (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .fill_flags   (fill_flags),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .in_tail_bits (in_tail_bits),
        .line_out     (line_out),
        .underrun     (underrun)
    );

    // Bit strobe: one high cycle in four.
    int div = 0;
    always @(negedge clk) begin
        if (rst) begin
            div = 0;
            bit_en <= 1'b0;
        end else begin
            div = (div + 1) % 4;
            bit_en <= (div == 3);
        end
    end

    logic ben_d = 1'b0;
    always @(posedge clk) ben_d <= bit_en;

    // Scoreboard queues
    bit    exp_bits[$];
    int    exp_len[$];
    int    exp_kind[$];
    string exp_tag[$];

    task automatic note(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_fcs_bits(input bit b[$]);
        logic [15:0] r;
        r = 16'hFFFF;
        foreach (b[i]) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
            else r = r >> 1;
        end
        return ~r;
    endfunction

    // Receiver model
    bit         got[$];
    bit         synced = 1'b0;
    int         ones = 0;
    logic [7:0] raw_sr = 8'h00;
    int         flags_seen = 0;
    int         frames_seen = 0;
    int         raw_zeros = 0;
    int         und_cnt = 0;
    int         stable_viol = 0;
    logic       last_line = 1'b1;

    task automatic score(input bit aborted);
        int    kind;
        int    len;
        string tag;
        bit    seg[$];
        int    bad;
        checks++;
        if (exp_len.size() == 0) begin
            failures++;
            $display("FAIL R3 unexpected %s actual=%0d expected=0", aborted ? "abort" : "frame", got.size());
            return;
        end
        kind = exp_kind.pop_front();
        len  = exp_len.pop_front();
        tag  = exp_tag.pop_front();
        for (int i = 0; i < len; i++) seg.push_back(exp_bits.pop_front());
        if (kind != (aborted ? 1 : 0)) begin
            failures++;
            $display("FAIL %s outcome actual=%0d expected=%0d (1 means abort)", tag, aborted, kind);
            return;
        end
        if (aborted) return;
        if (got.size() != len) begin
            failures++;
            $display("FAIL %s frame length actual=%0d expected=%0d", tag, got.size(), len);
            return;
        end
        bad = -1;
        for (int i = 0; i < len; i++) if (bad < 0 && got[i] != seg[i]) bad = i;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s bit %0d actual=%0d expected=%0d", tag, bad, got[bad], seg[bad]);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (underrun) und_cnt++;
            if (!ben_d && line_out !== last_line) stable_viol++;
            if (ben_d) begin
                bit b;
                b = line_out;
                if (!b) raw_zeros++;
                raw_sr = {b, raw_sr[7:1]};
                if (!synced) begin
                    if (raw_sr == 8'h7E) begin
                        synced = 1'b1;
                        ones = 0;
                        got.delete();
                        flags_seen++;
                    end
                end else if (b) begin
                    ones++;
                    got.push_back(1'b1);
                    if (ones == 7) begin
                        if (got.size() > 7) score(1'b1);
                        synced = 1'b0;
                        got.delete();
                    end
                end else begin
                    if (ones == 5) begin
                        ones = 0;
                    end else if (ones == 6) begin
                        for (int k = 0; k < 7; k++) if (got.size() > 0) void'(got.pop_back());
                        flags_seen++;
                        if (got.size() > 0) begin
                            frames_seen++;
                            score(1'b0);
                        end
                        got.delete();
                        ones = 0;
                    end else begin
                        got.push_back(1'b0);
                        ones = 0;
                    end
                end
            end
        end
        last_line = line_out;
    end

    task automatic wait_bits(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] d, input bit sof, input bit eof, input int tail);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid     = 1'b1;
        in_data      = d;
        in_sof       = sof;
        in_eof       = eof;
        in_tail_bits = 3'(tail);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d[], input int tail, input string tag, input bit starve);
        bit          cont[$];
        logic [15:0] f;
        int          n;
        int          nb;
        n = starve ? 1 : d.size();
        if (starve) begin
            exp_kind.push_back(1);
            exp_len.push_back(0);
        end else begin
            for (int i = 0; i < n; i++) begin
                nb = (i == n - 1 && tail != 0) ? tail : 8;
                for (int j = 0; j < nb; j++) cont.push_back(d[i][j]);
            end
            f = ref_fcs_bits(cont);
            for (int j = 0; j < 16; j++) cont.push_back(f[j]);
            foreach (cont[i]) exp_bits.push_back(cont[i]);
            exp_kind.push_back(0);
            exp_len.push_back(cont.size());
        end
        exp_tag.push_back(tag);
        for (int i = 0; i < n; i++) begin
            push_byte(d[i], i == 0, (i == n - 1) && !starve, (i == n - 1) ? tail : 0);
            if (i == 0) note(in_ready == 1'b0, "R8", "in_ready after accept", in_ready, 0);
        end
    endtask

    task automatic drain();
        while (exp_len.size() != 0) @(negedge clk);
        wait_bits(12);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] frm[];
        bit         digits[$];
        int         snap;

        repeat (6) @(negedge clk);
        note(line_out == 1'b1, "R1", "line_out in reset", line_out, 1);
        note(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        note(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
        rst = 1'b0;
        @(negedge clk);
        note(line_out == 1'b1, "R1", "line_out after reset", line_out, 1);

        // R2: mark fill
        wait_bits(4);
        snap = raw_zeros;
        wait_bits(24);
        note(raw_zeros == snap, "R2", "zeros during mark fill", raw_zeros - snap, 0);

        // R2: flag fill
        fill_flags = 1'b1;
        wait_bits(10);
        snap = flags_seen;
        wait_bits(40);
        note((flags_seen - snap) >= 4, "R2", "flags during flag fill", flags_seen - snap, 5);

        // R5: reference check value for the digit string
        for (int i = 0; i < 9; i++) for (int j = 0; j < 8; j++) digits.push_back(((8'h31 + i) >> j) & 1);
        note(ref_fcs_bits(digits) == 16'h906E, "R5", "model check value", ref_fcs_bits(digits), 16'h906E);

        frm = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send_frame(frm, 0, "R3 R5 digits", 1'b0);
        drain();

        frm = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
        send_frame(frm, 0, "R4 ones runs", 1'b0);
        drain();

        frm = '{8'hA5, 8'h3C, 8'h6F};
        send_frame(frm, 3, "R6 three tail bits", 1'b0);
        drain();

        frm = '{8'h81};
        send_frame(frm, 1, "R6 one tail bit", 1'b0);
        drain();

        // R9: stray byte without start marker
        snap = frames_seen;
        push_byte(8'hC3, 1'b0, 1'b0, 0);
        wait_bits(30);
        note(in_ready == 1'b1, "R9", "in_ready after stray byte", in_ready, 1);
        note(frames_seen == snap, "R9", "frames after stray byte", frames_seen - snap, 0);
        frm = '{8'h0F, 8'hE7};
        send_frame(frm, 0, "R9 frame after stray", 1'b0);
        drain();

        // R7: underrun abort
        snap = und_cnt;
        frm = '{8'h55, 8'hAA};
        send_frame(frm, 0, "R7 starved frame", 1'b1);
        drain();
        note(und_cnt == snap + 1, "R7", "underrun pulses", und_cnt - snap, 1);
        note(in_ready == 1'b1, "R7", "in_ready after abort", in_ready, 1);

        // Mark fill around a frame
        fill_flags = 1'b0;
        wait_bits(16);
        frm = '{8'h00, 8'h0F, 8'hF0};
        send_frame(frm, 0, "R2 R3 frame in mark fill", 1'b0);
        drain();
        snap = raw_zeros;
        wait_bits(24);
        note(raw_zeros == snap, "R2", "zeros after frame in mark fill", raw_zeros - snap, 0);

        note(stable_viol == 0, "R10", "line changes off strobe", stable_viol, 0);
        note(exp_len.size() == 0, "R3", "frames left undelivered", exp_len.size(), 0);
        finish_run();
    end

endmodule